// File: doc/BRIEF.md
# Page Protection Rights Evaluator

This block works out what a memory access may do to a page and whether the access in hand is allowed. It takes two protection key bits from the segment descriptor, one for supervisor state and one for user state. It also takes the current privilege state, a segment no-execute flag and the two-bit protection code held in the page entry. From these it derives read, write and execute rights. It then judges the current access against those rights. The access is an instruction fetch, a data load or a data store.

A caller presents one request per cycle, marked with a valid strobe. By default the result comes back from an output register one cycle later, with its own valid flag. A parameter removes the register, and the result then follows the inputs within the same cycle. When the valid flag is low, every result output reads zero. Walking the page table, forming the physical address and raising exceptions are left to the surrounding logic.

Top module: `prot_rights_eval`

## Requirements
- R1: The effective key is `usr_key` when `problem_state` is 1 and `sup_key` when `problem_state` is 0.
- R2: With effective key 0, protection codes 0, 1 and 2 give read and write, and code 3 gives read only.
- R3: With effective key 1, code 0 gives no read and no write, codes 1 and 3 give read only, and code 2 gives read and write.
- R4: `ex_ok` is 1 exactly when `no_exec` is 0, whatever the key and code.
- R5: When `is_fetch` is 1, the access is granted exactly when execute is present, whatever the value of `is_write`.
- R6: When `is_fetch` is 0, a store (`is_write`=1) is granted exactly when write is present, and a load (`is_write`=0) is granted exactly when read is present.
- R7: For a valid result, exactly one of `granted` and `violation` is 1. The `violation` output is a protection fault and is never 1 while `out_valid` is 0.
- R8: With `REG_OUT`=1, every request strobed on `in_valid` produces exactly one result with `out_valid`=1, in the following cycle, and requests keep their order.
- R9: While reset is held, and in any cycle where `out_valid` is 0, all rights outputs, `granted` and `violation` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| sup_key | input | 1 | Segment key used in supervisor state |
| usr_key | input | 1 | Segment key used in problem (user) state |
| problem_state | input | 1 | 1 = user privilege, 0 = supervisor |
| no_exec | input | 1 | Segment forbids instruction fetch |
| prot_code | input | 2 | Page protection code, 0 to 3 |
| is_write | input | 1 | Data access is a store |
| is_fetch | input | 1 | Access is an instruction fetch |
| out_valid | output | 1 | Result valid |
| rd_ok | output | 1 | Read right |
| wr_ok | output | 1 | Write right |
| ex_ok | output | 1 | Execute right |
| granted | output | 1 | Access allowed |
| violation | output | 1 | Protection violation |

## Verification
The write flag and the fetch flag can both be set in the same request. The bench drives every combination of the eight input bits, so the two flags fall together while the page is writable but not executable, and also while it is executable but read-only. Each such result is judged by the fetch rule alone. The two key bits are also set to opposite values under both privilege states, so a key taken from the wrong privilege level would flip the decoded row.

// File: rtl/prot_eval_pkg.sv
package prot_eval_pkg;

   localparam int PROT_CODE_W = 2;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } rights_t;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_t;

endpackage

// File: rtl/prot_key_sel.sv
module prot_key_sel (
   input  logic sup_key,
   input  logic usr_key,
   input  logic problem_state,
   output logic eff_key
);
   // the key bit belonging to the current privilege level wins
   always_comb begin
      eff_key = problem_state ? usr_key : sup_key;
   end
endmodule

// File: rtl/prot_rights_dec.sv
module prot_rights_dec
   import prot_eval_pkg::*;
#(
   parameter int CODE_W = PROT_CODE_W
) (
   input  logic              eff_key,
   input  logic              no_exec,
   input  logic [CODE_W-1:0] code,
   output rights_t           rights
);
   localparam logic [CODE_W-1:0] CODE_RO  = CODE_W'(3);
   localparam logic [CODE_W-1:0] CODE_NONE = CODE_W'(0);
   localparam logic [CODE_W-1:0] CODE_RW  = CODE_W'(2);

   generate
      if (CODE_W != 2) begin : g_bad_width
         $error("prot_rights_dec: CODE_W must be 2");
      end
   endgenerate

   always_comb begin
      if (!eff_key) begin
         // privileged decoding: only one read-only code
         rights.rd = 1'b1;
         rights.wr = (code != CODE_RO);
      end else begin
         // restricted decoding: one empty code, one writable code
         rights.rd = (code != CODE_NONE);
         rights.wr = (code == CODE_RW);
      end
      rights.ex = ~no_exec;
   end
endmodule

// File: rtl/prot_access_chk.sv
module prot_access_chk
   import prot_eval_pkg::*;
(
   input  rights_t rights,
   input  logic    is_write,
   input  logic    is_fetch,
   output logic    granted
);
   acc_kind_t kind;

   always_comb begin
      if (is_fetch)      kind = ACC_FETCH;
      else if (is_write) kind = ACC_STORE;
      else               kind = ACC_LOAD;
   end

   always_comb begin
      unique case (kind)
         ACC_FETCH: granted = rights.ex;
         ACC_STORE: granted = rights.wr;
         default:   granted = rights.rd;
      endcase
   end
endmodule

// File: rtl/prot_rights_eval.sv
module prot_rights_eval
   import prot_eval_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   sup_key,
   input  logic                   usr_key,
   input  logic                   problem_state,
   input  logic                   no_exec,
   input  logic [PROT_CODE_W-1:0] prot_code,
   input  logic                   is_write,
   input  logic                   is_fetch,
   output logic                   out_valid,
   output logic                   rd_ok,
   output logic                   wr_ok,
   output logic                   ex_ok,
   output logic                   granted,
   output logic                   violation
);
   typedef struct packed {
      logic    vld;
      rights_t rights;
      logic    grant;
      logic    viol;
   } result_t;

   generate
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("prot_rights_eval: REG_OUT must be 0 or 1");
      end
   endgenerate

   logic    eff_key;
   rights_t comb_rights;
   logic    comb_grant;
   result_t comb_res;
   result_t out_res;

   prot_key_sel u_key (
      .sup_key       (sup_key),
      .usr_key       (usr_key),
      .problem_state (problem_state),
      .eff_key       (eff_key)
   );

   prot_rights_dec #(.CODE_W(PROT_CODE_W)) u_dec (
      .eff_key (eff_key),
      .no_exec (no_exec),
      .code    (prot_code),
      .rights  (comb_rights)
   );

   prot_access_chk u_chk (
      .rights   (comb_rights),
      .is_write (is_write),
      .is_fetch (is_fetch),
      .granted  (comb_grant)
   );

   // results are zeroed whenever no request is present
   always_comb begin
      comb_res = '0;
      if (in_valid) begin
         comb_res.vld    = 1'b1;
         comb_res.rights = comb_rights;
         comb_res.grant  = comb_grant;
         comb_res.viol   = ~comb_grant;
      end
   end

   generate
      if (REG_OUT == 1) begin : g_reg
         result_t res_q;
         logic    started_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res_q     <= '0;
               started_q <= 1'b0;
            end else begin
               res_q     <= comb_res;
               started_q <= 1'b1;
            end
         end
         assign out_res = res_q;

         // R8
         valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            started_q |-> (out_valid == $past(in_valid)));
      end else begin : g_comb
         assign out_res = comb_res;
      end
   endgenerate

   assign out_valid = out_res.vld;
   assign rd_ok     = out_res.rights.rd;
   assign wr_ok     = out_res.rights.wr;
   assign ex_ok     = out_res.rights.ex;
   assign granted   = out_res.grant;
   assign violation = out_res.viol;

   // R7
   grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (granted != violation));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ({rd_ok, wr_ok, ex_ok, granted, violation} == 5'b0));

   // R2
   wr_implies_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> rd_ok);

   // R5
   fetch_needs_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_fetch && comb_grant) |-> comb_rights.ex);

   // R4
   noexec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && no_exec) |-> !comb_rights.ex);
endmodule

// File: tb/tb_prot_rights_eval.sv
module tb_prot_rights_eval;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       sup_key = 1'b0, usr_key = 1'b0, problem_state = 1'b0, no_exec = 1'b0;
   logic [1:0] prot_code = 2'd0;
   logic       is_write = 1'b0, is_fetch = 1'b0;
   logic       out_valid, rd_ok, wr_ok, ex_ok, granted, violation;

   int checks = 0;
   int errors = 0;
   int cycle  = 0;
   int pushed = 0;
   int popped = 0;

   typedef struct {
      logic [4:0] res;   // rd wr ex grant viol
      logic       key;
      logic       fetch;
      int         stamp;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cycle <= cycle + 1;

   prot_rights_eval #(.REG_OUT(1)) dut (
      .clk, .rst_n, .in_valid, .sup_key, .usr_key, .problem_state, .no_exec,
      .prot_code, .is_write, .is_fetch, .out_valid, .rd_ok, .wr_ok, .ex_ok,
      .granted, .violation
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // model from the requirements
   function automatic exp_t model(input logic sk, uk, ps, nx,
                                  input logic [1:0] pc, input logic w, f);
      exp_t e;
      logic k, r, wr, x, g;
      k = ps ? uk : sk;                      // R1
      if (!k) begin r = 1'b1; wr = (pc != 2'd3); end          // R2
      else begin r = (pc != 2'd0); wr = (pc == 2'd2); end     // R3
      x = !nx;                               // R4
      g = f ? x : (w ? wr : r);              // R5, R6
      e.res = {r, wr, x, g, !g};
      e.key = k;
      e.fetch = f;
      e.stamp = 0;
      return e;
   endfunction

   task automatic drive(input logic sk, uk, ps, nx,
                        input logic [1:0] pc, input logic w, f);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1; sup_key = sk; usr_key = uk; problem_state = ps;
      no_exec = nx; prot_code = pc; is_write = w; is_fetch = f;
      e = model(sk, uk, ps, nx, pc, w, f);
      e.stamp = cycle;
      sb.push_back(e);
      pushed++;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      {sup_key, usr_key, problem_state, no_exec, is_write, is_fetch} = 6'h3f;
      prot_code = 2'd2;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8", "unexpected result", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               popped++;
               check(cycle == e.stamp + 1, "R8", "latency", cycle, e.stamp + 1);
               check({rd_ok, wr_ok} == e.res[4:3], e.key ? "R3" : "R2",
                     "rd/wr", {rd_ok, wr_ok}, e.res[4:3]);
               check(ex_ok == e.res[2], "R4", "ex", ex_ok, e.res[2]);
               check(granted == e.res[1], e.fetch ? "R5" : "R6",
                     "grant", granted, e.res[1]);
               check(violation == e.res[0], "R7", "violation", violation, e.res[0]);
            end
         end else begin
            check({rd_ok, wr_ok, ex_ok, granted, violation} == 5'b0, "R9",
                  "idle outputs", {rd_ok, wr_ok, ex_ok, granted, violation}, 0);
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycle);
      finish_run();
   end

   initial begin
      in_valid = 1'b1;
      {sup_key, usr_key, problem_state, no_exec, is_write, is_fetch} = 6'h3f;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state, even with a request strobed
      check({out_valid, rd_ok, wr_ok, ex_ok, granted, violation} == 6'b0, "R9",
            "reset outputs", {out_valid, rd_ok, wr_ok, ex_ok, granted, violation}, 0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R1: opposite key bits under both privilege states
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0); // user key 1, code 0: store denied
      drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0); // supervisor key 0: store granted
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0); // key 1 read-only load
      drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0); // key 0 code 1 store granted
      idle();

      // every input combination, with gaps
      for (int i = 0; i < 256; i++) begin
         logic [7:0] v;
         v = 8'(i);
         drive(v[7], v[6], v[5], v[4], v[3:2], v[1], v[0]);
         if (i % 7 == 3) idle();
      end

      // R5: fetch and store together on a writable, non-executable page
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1);
      // R5: fetch and store together on a read-only, executable page
      drive(1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1);
      idle();
      idle();
      idle();
      check(sb.size() == 0, "R8", "results outstanding", sb.size(), 0);
      check(popped == pushed, "R8", "result count", popped, pushed);
      finish_run();
   end
endmodule